// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave for a two-wire serial bus (I2C-style) that fronts a byte-addressed memory with an 18-bit word address. It oversamples SCL and SDA on the system clock, filters short glitches, and detects Start and Stop. It compares the incoming device byte with its fixed type code and with a board strap. It then accepts a two-byte word address and handles several kinds of access: single-byte writes, partial-page writes, full-page writes, random reads and sequential reads.

Written bytes first collect in a 256-byte page buffer. A Stop copies them into the array during a self-timed busy period. While that period lasts, the device ignores its own address, so a master can poll for completion. A write-protect input blocks data bytes from reaching the buffer.

The array is a behavioural RAM of 2^MEM_AW bytes, indexed by the low address bits. SDA is an open-drain line: the block only ever pulls it low.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset the block does not pull SDA low and is not busy.
- R2: A falling SDA while SCL is high is a Start and restarts byte reception with the device byte. A rising SDA while SCL is high is a Stop, which releases SDA and ends the transaction.
- R3: Input bits are taken on SCL rising edges and output bits change only while SCL is low. Every byte moves most-significant bit first, followed by one acknowledge bit (SDA low means ACK).
- R4: The device byte is acknowledged only when its bits 7:4 are 1010 and its bit 3 equals strap_i. Bits 2:1 carry word-address bits 17:16, and bit 0 selects read (1) or write (0).
- R5: In a write, the two bytes after the device byte give word-address bits 15:8 and then bits 7:0, and both are acknowledged.
- R6: Each acknowledged data byte goes to the current address and advances the counter. The bytes reach the array only after a Stop, and the whole write needs no more than WR_CYCLES clocks.
- R7: During a write, the low 8 address bits wrap within the current 256-byte page, and the high bits stay the same.
- R8: While wp_i is high, data bytes are answered with NACK and the array is left unchanged. The address bytes are still acknowledged.
- R9: After a Stop that ends a write with data, the block is busy for WR_CYCLES clocks. During that time it does not acknowledge its device byte, and afterwards it does.
- R10: A random read works as follows: a write of the device byte and address, then a repeated Start, then a read device byte. The byte returned is the one stored at that address.
- R11: In a read, the address counter increments after each byte sent. It rolls over from 0x3FFFF to 0x00000.
- R12: A NACK from the master after a read byte ends the read, and SDA is not driven again until the next Start.
- R13: A repeated Start that follows write data without a Stop discards the buffered bytes, so no write cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (resolved wired-AND) |
| strap_i | input | 1 | Address strap compared with device-byte bit 3 |
| wp_i | input | 1 | Write protect, high blocks array writes |
| sda_low_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
On every cycle, the assertions check several things: the SDA drive changes only while the filtered SCL is low; a Start or Stop always releases the line; and a Stop that ends a write raises the busy state, which in turn never drives SDA. Only the bench's bus transactions can show the rest: that data written at one address reads back there, page wrap, address rollover, the NACK under write protect, polling during busy, and the discard of write data on a repeated Start. A behavioural byte map in the bench supplies every expected read value.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT, S_RDAT
  } eep_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_line_filter.sv
module eep_line_filter #(
  parameter int LINES = 2,
  parameter int FLT   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] flt_o
);
  localparam int FCW = $clog2(FLT + 1);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]     sync_q;
    logic [FCW-1:0] cnt_q;
    logic           lvl_q;

    // level accepted only after FLT consecutive disagreeing samples
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= 2'b11;
        cnt_q  <= '0;
        lvl_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw_i[g]};
        if (sync_q[1] == lvl_q) begin
          cnt_q <= '0;
        end else if (cnt_q == FCW'(FLT - 1)) begin
          lvl_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
    assign flt_o[g] = lvl_q;
  end
endmodule

// File: rtl/eep_write_engine.sv
module eep_write_engine #(
  parameter int AW        = 18,
  parameter int PAGE      = 256,
  parameter int WR_CYCLES = 400
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(PAGE)-1:0]  idx_i,
  input  logic [7:0]               data_i,
  input  logic                     go_i,
  input  logic                     clr_i,
  input  logic [AW-$clog2(PAGE)-1:0] page_i,
  output logic                     busy_o,
  output logic                     any_o,
  output logic                     commit_en_o,
  output logic [AW-1:0]            commit_addr_o,
  output logic [7:0]               commit_data_o
);
  localparam int PW = $clog2(PAGE);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   vld_q;
  logic [CW-1:0]     cnt_q;
  logic [AW-PW-1:0]  base_q;
  logic [PW-1:0]     cidx;
  logic              in_copy;

  assign cidx    = cnt_q[PW-1:0];
  assign in_copy = busy_o && (cnt_q < CW'(PAGE));

  always_ff @(posedge clk_i) begin
    if (we_i) pbuf[idx_i] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      base_q <= '0;
    end else begin
      if (go_i) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
        base_q <= page_i;
      end else if (busy_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(WR_CYCLES - 1)) busy_o <= 1'b0;
        if (in_copy) vld_q[cidx] <= 1'b0;
      end
      if (clr_i && !busy_o) vld_q <= '0;
      if (we_i) vld_q[idx_i] <= 1'b1;
    end
  end

  assign any_o         = |vld_q;
  assign commit_en_o   = in_copy && vld_q[cidx];
  assign commit_addr_o = {base_q, cidx};
  assign commit_data_o = pbuf[cidx];
endmodule

// File: rtl/eep_slave_fsm.sv
module eep_slave_fsm
  import eep_pkg::*;
#(
  parameter int AW = 18,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          strap_i,
  input  logic          wp_i,
  input  logic          busy_i,
  input  logic          any_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic          buf_we_o,
  output logic [PW-1:0] buf_idx_o,
  output logic [7:0]    buf_data_o,
  output logic          wr_go_o,
  output logic          wr_clr_o,
  output logic          sda_low_o,
  output logic          start_o,
  output logic          stop_o
);
  localparam int HW = AW - 16;

  eep_state_e    st_q;
  logic          scl_q, sda_q, ack_ph_q, acked_q, rw_q, mack_q;
  logic [3:0]    bit_q;
  logic [7:0]    sh_q, tx_q, ahi_q;
  logic [HW-1:0] top_q;
  logic          scl_rise, scl_fall, dev_ok;

  assign scl_rise = scl_i && !scl_q;
  assign scl_fall = !scl_i && scl_q;
  assign start_o  = scl_i && scl_q && sda_q && !sda_i;
  assign stop_o   = scl_i && scl_q && !sda_q && sda_i;
  assign dev_ok   = (sh_q[7:4] == DEV_TYPE) && (sh_q[3] == strap_i) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
      ack_ph_q <= 1'b0; acked_q <= 1'b0; rw_q <= 1'b0; mack_q <= 1'b0;
      bit_q <= '0; sh_q <= '0; tx_q <= '0; ahi_q <= '0; top_q <= '0;
      addr_o <= '0; buf_we_o <= 1'b0; buf_idx_o <= '0; buf_data_o <= '0;
      wr_go_o <= 1'b0; wr_clr_o <= 1'b0; sda_low_o <= 1'b0;
    end else begin
      scl_q    <= scl_i;
      sda_q    <= sda_i;
      buf_we_o <= 1'b0;
      wr_go_o  <= 1'b0;
      wr_clr_o <= 1'b0;
      if (start_o) begin
        st_q <= S_DEV; bit_q <= '0; ack_ph_q <= 1'b0;
        sda_low_o <= 1'b0; wr_clr_o <= 1'b1;
      end else if (stop_o) begin
        st_q <= S_IDLE; ack_ph_q <= 1'b0; sda_low_o <= 1'b0;
        wr_go_o <= any_i && !busy_i;
      end else if (st_q != S_IDLE) begin
        if (scl_rise) begin
          if (ack_ph_q) mack_q <= !sda_i;
          else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[6:0], sda_i};
          end
        end else if (scl_fall) begin
          if (ack_ph_q) begin
            // end of acknowledge bit
            ack_ph_q <= 1'b0; bit_q <= '0; sda_low_o <= 1'b0;
            if (!acked_q || (st_q == S_RDAT && !mack_q)) begin
              st_q <= S_IDLE;
            end else begin
              case (st_q)
                S_DEV:  st_q <= rw_q ? S_RDAT : S_AHI;
                S_AHI:  st_q <= S_ALO;
                S_ALO:  st_q <= S_WDAT;
                default: ;
              endcase
              if ((st_q == S_DEV && rw_q) || st_q == S_RDAT) begin
                tx_q      <= rd_data_i;
                sda_low_o <= !rd_data_i[7];
                addr_o    <= addr_o + 1'b1;
              end
            end
          end else if (bit_q == 4'd8) begin
            ack_ph_q <= 1'b1;
            acked_q  <= 1'b1;
            sda_low_o <= (st_q != S_RDAT);
            case (st_q)
              S_DEV: begin
                acked_q <= dev_ok; sda_low_o <= dev_ok;
                if (dev_ok) begin rw_q <= sh_q[0]; top_q <= sh_q[HW:1]; end
              end
              S_AHI: ahi_q <= sh_q;
              S_ALO: addr_o <= {top_q, ahi_q, sh_q};
              S_WDAT: begin
                acked_q <= !wp_i; sda_low_o <= !wp_i;
                if (!wp_i) begin
                  buf_we_o   <= 1'b1;
                  buf_idx_o  <= addr_o[PW-1:0];
                  buf_data_o <= sh_q;
                  addr_o[PW-1:0] <= addr_o[PW-1:0] + 1'b1;
                end
              end
              default: ;
            endcase
          end else if (st_q == S_RDAT) begin
            tx_q      <= {tx_q[6:0], 1'b0};
            sda_low_o <= !tx_q[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter int AW        = 18,
  parameter int MEM_AW    = 12,
  parameter int PAGE      = 256,
  parameter int WR_CYCLES = 400,
  parameter int FLT       = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_i,
  input  logic wp_i,
  output logic sda_low_o
);
  localparam int PW = $clog2(PAGE);

  logic [1:0]    lines_f;
  logic          scl_f, sda_f;
  logic [AW-1:0] addr, commit_addr;
  logic [7:0]    rd_data, buf_data, commit_data;
  logic [PW-1:0] buf_idx;
  logic          buf_we, wr_go, wr_clr, busy, any, commit_en, start_det, stop_det;

  eep_line_filter #(.LINES(2), .FLT(FLT)) u_flt (
    .clk_i, .rst_ni, .raw_i({sda_i, scl_i}), .flt_o(lines_f)
  );
  assign scl_f = lines_f[0];
  assign sda_f = lines_f[1];

  eep_slave_fsm #(.AW(AW), .PW(PW)) u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_f), .sda_i(sda_f), .strap_i, .wp_i,
    .busy_i(busy), .any_i(any), .rd_data_i(rd_data), .addr_o(addr),
    .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_data_o(buf_data),
    .wr_go_o(wr_go), .wr_clr_o(wr_clr), .sda_low_o,
    .start_o(start_det), .stop_o(stop_det)
  );

  eep_write_engine #(.AW(AW), .PAGE(PAGE), .WR_CYCLES(WR_CYCLES)) u_wr (
    .clk_i, .rst_ni, .we_i(buf_we), .idx_i(buf_idx), .data_i(buf_data),
    .go_i(wr_go), .clr_i(wr_clr), .page_i(addr[AW-1:PW]),
    .busy_o(busy), .any_o(any), .commit_en_o(commit_en),
    .commit_addr_o(commit_addr), .commit_data_o(commit_data)
  );

  logic [7:0] mem [2**MEM_AW];

  always_ff @(posedge clk_i) begin
    if (commit_en) mem[commit_addr[MEM_AW-1:0]] <= commit_data;
  end
  assign rd_data = mem[addr[MEM_AW-1:0]];
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_f,
  input logic sda_low,
  input logic busy,
  input logic start,
  input logic stop,
  input logic wr_go
);
  p_sda_moves_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_low) |-> !scl_f);
  p_start_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !sda_low);
  p_stop_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !sda_low);
  p_busy_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_low);
  p_go_enters_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go |=> busy);
  p_go_after_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go |-> !busy);
endmodule

bind eep_i2c_slave eep_i2c_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_f(scl_f), .sda_low(sda_low_o),
  .busy(busy), .start(start_det), .stop(stop_det), .wr_go(wr_go)
);

// File: tb/eep_i2c_slave_test.sv
module eep_i2c_slave_test;
  localparam int CLK_P = 10;
  localparam int Q     = 6;
  localparam int WR    = 400;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_low_o, sda_bus;
  int n_chk = 0, n_bad = 0;
  logic [7:0] ref_mem [int];

  always #(CLK_P/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_low_o;

  eep_i2c_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(1'b1), .wp_i(wp), .sda_low_o(sda_low_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every clock: slave SDA drive must hold while SCL stays high (R3)
  logic scl_prev = 1'b1, sl_prev = 1'b0;
  always begin
    @(posedge clk); #(CLK_P/4);
    if (rst_n && scl && scl_prev) chk(sda_low_o == sl_prev, "R3 drive moved with SCL high", sda_low_o, sl_prev);
    scl_prev = scl; sl_prev = sda_low_o;
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
  task automatic i2c_stop(); sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); wq(); endtask
  task automatic put_bit(input logic b, output logic rb);
    sda_m = b; wq(); scl = 1; wq(); rb = sda_bus; wq(); scl = 0; wq();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic rb;
    for (int i = 7; i >= 0; i--) put_bit(b[i], rb);
    put_bit(1'b1, rb);
    ack = !rb;
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic rb;
    for (int i = 7; i >= 0; i--) begin put_bit(1'b1, rb); d[i] = rb; end
    put_bit(!mack, rb);
  endtask

  function automatic logic [7:0] dev(input int a, input logic rd, input logic strap);
    return {4'b1010, strap, a[17:16], rd};
  endfunction
  function automatic int midx(input int a); return a & 'hFFF; endfunction

  task automatic set_addr(input int a, input string tag);
    logic ack;
    send_byte(dev(a, 0, 1), ack); chk(ack, {tag, " R4 device ack"}, ack, 1);
    send_byte(a[15:8], ack);      chk(ack, "R5 high address ack", ack, 1);
    send_byte(a[7:0], ack);       chk(ack, "R5 low address ack", ack, 1);
  endtask

  task automatic do_write(input int a, input logic [7:0] d[$]);
    logic ack;
    i2c_start(); set_addr(a, "write");
    foreach (d[i]) begin
      send_byte(d[i], ack);
      chk(ack == !wp, wp ? "R8 data NACK under protect" : "R6 data ack", ack, !wp);
      if (!wp) ref_mem[midx((a & 'h3FF00) | ((a + i) & 'hFF))] = d[i];
    end
    i2c_stop();
  endtask

  task automatic do_read(input int a, input int n, input string tag);
    logic ack; logic [7:0] d;
    i2c_start(); set_addr(a, tag);
    i2c_start();
    send_byte(dev(a, 1, 1), ack); chk(ack, {tag, " read device ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk(d == ref_mem[midx((a + k) & 'h3FFFF)], tag, d, ref_mem[midx((a + k) & 'h3FFFF)]);
    end
    i2c_stop();
  endtask

  task automatic wait_busy(); repeat (WR + 60) @(negedge clk); endtask

  initial begin
    repeat (190000) @(negedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ack, rb; logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(sda_low_o == 0, "R1 SDA released after reset", sda_low_o, 0);

    // wrong strap level: no acknowledge
    i2c_start(); send_byte(dev(0, 0, 0), ack); i2c_stop();
    chk(!ack, "R4 strap mismatch NACK", ack, 0);
    i2c_start(); send_byte(8'hB8, ack); i2c_stop();
    chk(!ack, "R4 type code mismatch NACK", ack, 0);

    // single byte write, then poll while busy
    do_write('h00010, '{8'hA5});
    i2c_start(); send_byte(dev(0, 0, 1), ack); i2c_stop();
    chk(!ack, "R9 NACK while write busy", ack, 0);
    wait_busy();
    i2c_start(); send_byte(dev(0, 0, 1), ack); i2c_stop();
    chk(ack, "R9 ACK after busy ends", ack, 1);
    chk(sda_low_o == 0, "R2 SDA released after Stop", sda_low_o, 0);
    do_read('h00010, 1, "R10 random read");

    // partial page, sequential read
    do_write('h00120, '{8'h11, 8'h22, 8'h33});
    wait_busy();
    do_read('h00120, 3, "R6 partial page readback");

    // wrap inside a page
    do_write('h002FE, '{8'h01, 8'h02, 8'h03, 8'h04});
    wait_busy();
    do_read('h00200, 2, "R7 wrapped bytes");
    do_read('h002FE, 2, "R7 bytes before wrap");

    // write protect
    wp = 1;
    do_write('h00010, '{8'h5A});
    wp = 0;
    i2c_start(); send_byte(dev(0, 0, 1), ack); i2c_stop();
    chk(ack, "R8 protected write starts no busy", ack, 1);
    do_read('h00010, 1, "R8 protected byte unchanged");

    // address rollover
    do_write('h3FFFF, '{8'h77}); wait_busy();
    do_write('h00000, '{8'h66}); wait_busy();
    do_read('h3FFFF, 2, "R11 rollover read");

    // master NACK ends read
    i2c_start(); set_addr('h00120, "R12");
    i2c_start(); send_byte(dev(0, 1, 1), ack);
    recv_byte(1'b0, d);
    chk(d == 8'h11, "R12 byte before NACK", d, 8'h11);
    for (int i = 0; i < 9; i++) begin
      put_bit(1'b1, rb);
      chk(rb == 1'b1, "R12 SDA idle after NACK", rb, 1);
    end
    i2c_stop();

    // repeated Start discards buffered data
    do_write('h00400, '{8'h12}); wait_busy();
    i2c_start(); set_addr('h00400, "R13");
    send_byte(8'h99, ack); chk(ack, "R13 data ack", ack, 1);
    i2c_start(); i2c_stop();
    i2c_start(); send_byte(dev(0, 0, 1), ack); i2c_stop();
    chk(ack, "R13 no write cycle after abort", ack, 1);
    do_read('h00400, 1, "R13 old byte kept");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule